// File: doc/BRIEF.md
# Power Mode Controller with Deglitched Supply Flags

This block is the mode sequencer for a two-channel switching regulator controller. It reads digitized supply-good flags, a limp-home request and a software idle bit. It moves between four modes: sleep, idle, limp-home and active. Each of those seven deciding inputs passes through its own deglitch filter before the mode can change. A short glitch therefore never moves the machine.

From the mode, the block derives several outputs:
- a one-cycle register-file reset strobe;
- read and write permissions for the serial register port;
- a backup-regulation enable for limp-home;
- one switching enable per channel.

Each channel enable combines that channel's PWM pin, its PWM register bit and its bootstrap-undervoltage flag. After a direct wake from sleep, the channel enables stay off for a programmable activation delay.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `pm_state` encodes the mode as SLEEP=0, IDLE=1, LIMP=2, ACTIVE=3, and mode changes happen only on rising clock edges.
- R2: A deciding input changes the mode only after it has held its new value at three consecutive rising edges. The mode register then updates on the following edge, which is the fourth edge after the input change. A change that lasts two cycles or less has no effect on the mode.
- R3: In IDLE, `sw_en` is all zero. `spi_rd_en` and `spi_wr_en` are both 1 when the filtered logic-supply flag is good and both 0 when it is not.
- R4: While `rst_n` is low, and until the first rising edge after its release, the mode is SLEEP, `regs_rst` is 1, and `sw_en`, `spi_rd_en`, `spi_wr_en` and `limp_reg_en` are all 0.
- R5: Every entry into LIMP raises `regs_rst` in the same cycle in which `pm_state` first shows LIMP.
- R6: `limp_reg_en` is 1 exactly when the mode is LIMP and the filtered input-supply and external-regulator flags are both good.
- R7: In LIMP, `spi_wr_en` is 0, and `spi_rd_en` follows the filtered logic-supply flag.
- R8: `sw_en[i]` is 1 only when all of the following hold:
  - the mode is ACTIVE;
  - the activation delay has elapsed;
  - `pwm_pin[i]` or `pwm_bit[i]` is high;
  - `bst_uv[i]` is low.

  The pin and bit inputs act without filtering in the same cycle.
- R9: After a direct SLEEP-to-ACTIVE transition at edge E, `sw_en` stays 0 through edge E+ACT_CYC-1 and may assert from edge E+ACT_CYC on. Entering ACTIVE from IDLE imposes no delay.
- R10: The next mode is chosen by priority, first match wins:
  1. Input supply not good selects SLEEP.
  2. Limp-home request selects LIMP.
  3. Idle bit selects IDLE.
  4. Enable together with the internal regulator, external regulator and logic supply all good selects ACTIVE.
  5. Otherwise the next mode is SLEEP.
- R11: `regs_rst` is high for exactly one cycle per entry into SLEEP or LIMP.
- R12: In SLEEP, `spi_rd_en` and `spi_wr_en` are both 0 regardless of the logic-supply flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_good | input | 1 | Input supply above its turn-on level |
| en_good | input | 1 | Enable / undervoltage pin good |
| ivcc_good | input | 1 | Internal regulator good |
| ivcc_ext_good | input | 1 | External regulator good |
| vdd_good | input | 1 | Logic supply good |
| limp_req | input | 1 | Limp-home request |
| sw_idle | input | 1 | Software idle bit |
| pwm_pin | input | NCH | Per-channel PWM input pin |
| pwm_bit | input | NCH | Per-channel PWM register bit |
| bst_uv | input | NCH | Per-channel bootstrap undervoltage flag |
| pm_state | output | 2 | Current mode |
| regs_rst | output | 1 | Register-file reset strobe |
| spi_rd_en | output | 1 | Serial register reads permitted |
| spi_wr_en | output | 1 | Serial register writes permitted |
| limp_reg_en | output | 1 | Backup regulation enabled in limp-home |
| sw_en | output | NCH | Per-channel switching enable |

## Verification
The bench drops the input supply for two cycles while active. A filter that is too short, or that does not restart its count, would fall into SLEEP and strobe the register reset.

It counts edges after a wake from sleep. An off-by-one activation counter would enable switching one cycle early or late. A counter applied on the IDLE-to-ACTIVE path would withhold switching that should start at once.

It raises the idle bit and the limp request together. This exposes a wrong priority order.

In LIMP it also checks the following:
- a write permission that leaks through;
- a reset strobe that stays high for more than one cycle;
- backup regulation that ignores the external regulator.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_SLEEP  = 2'd0,
    PM_IDLE   = 2'd1,
    PM_LIMP   = 2'd2,
    PM_ACTIVE = 2'd3
  } pm_state_e;

  // positions of the deciding inputs in the filtered vector
  localparam int unsigned DEC_VIN  = 0;
  localparam int unsigned DEC_EN   = 1;
  localparam int unsigned DEC_IVCC = 2;
  localparam int unsigned DEC_EXT  = 3;
  localparam int unsigned DEC_VDD  = 4;
  localparam int unsigned DEC_LIMP = 5;
  localparam int unsigned DEC_IDLE = 6;
  localparam int unsigned N_DEC    = 7;

endpackage

// File: rtl/pmc_deglitch.sv
module pmc_deglitch #(
  parameter int unsigned FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic qual
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          qual_q, qual_d;
  logic          upd_en;

  always_comb begin
    cnt_d  = '0;
    qual_d = qual_q;
    if (raw != qual_q) begin
      if (cnt_q == CW'(FILT_CYC - 1)) begin
        qual_d = raw;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  assign upd_en = (cnt_d != cnt_q) || (qual_d != qual_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      qual_q <= qual_d;
    end
  end

  assign qual = qual_q;

  generate
    if (FILT_CYC >= 3) begin : g_chk
      AST_FILT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_q != $past(qual_q)) |->
          ($past(raw, 1) == qual_q && $past(raw, 2) == qual_q && $past(raw, 3) == qual_q)); // R2
    end
  endgenerate

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int unsigned ACT_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEC-1:0] dec,
  output pm_state_e        state,
  output logic             reg_rst,
  output logic             act_ready
);
  localparam int unsigned AW = $clog2(ACT_CYC + 1);

  pm_state_e     state_q, state_nxt;
  logic          rst_q, rst_d;
  logic [AW-1:0] act_q, act_d;
  logic          all_ok;

  assign all_ok = dec[DEC_EN] & dec[DEC_IVCC] & dec[DEC_EXT] & dec[DEC_VDD];

  always_comb begin
    if (!dec[DEC_VIN])      state_nxt = PM_SLEEP;
    else if (dec[DEC_LIMP]) state_nxt = PM_LIMP;
    else if (dec[DEC_IDLE]) state_nxt = PM_IDLE;
    else if (all_ok)        state_nxt = PM_ACTIVE;
    else                    state_nxt = PM_SLEEP;
  end

  always_comb begin
    rst_d = (state_nxt != state_q) &&
            (state_nxt == PM_SLEEP || state_nxt == PM_LIMP);
  end

  always_comb begin
    if (state_nxt != PM_ACTIVE)                           act_d = '0;
    else if (state_q == PM_SLEEP)                         act_d = AW'(ACT_CYC);
    else if (act_q != '0)                                 act_d = act_q - AW'(1);
    else                                                  act_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_SLEEP;
      rst_q   <= 1'b1;
      act_q   <= '0;
    end else begin
      state_q <= state_nxt;
      rst_q   <= rst_d;
      act_q   <= act_d;
    end
  end

  assign state     = state_q;
  assign reg_rst   = rst_q;
  assign act_ready = (act_q == '0);

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rst |=> !reg_rst); // R11
  AST_RST_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != $past(state_q)) && (state_q == PM_SLEEP || state_q == PM_LIMP)) |-> reg_rst); // R5
  AST_VIN_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !dec[DEC_VIN] |=> (state_q == PM_SLEEP)); // R10
  AST_ACT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == PM_SLEEP && state_q == PM_ACTIVE) |-> !act_ready); // R9

endmodule

// File: rtl/pmc_chan_gate.sv
module pmc_chan_gate (
  input  logic active,
  input  logic act_ready,
  input  logic pwm_pin,
  input  logic pwm_bit,
  input  logic bst_uv,
  output logic sw_en
);
  logic req;

  assign req   = pwm_pin | pwm_bit;
  assign sw_en = active & act_ready & req & ~bst_uv;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned NCH      = 2,
  parameter int unsigned FILT_CYC = 3,
  parameter int unsigned ACT_CYC  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vin_good,
  input  logic           en_good,
  input  logic           ivcc_good,
  input  logic           ivcc_ext_good,
  input  logic           vdd_good,
  input  logic           limp_req,
  input  logic           sw_idle,
  input  logic [NCH-1:0] pwm_pin,
  input  logic [NCH-1:0] pwm_bit,
  input  logic [NCH-1:0] bst_uv,
  output logic [1:0]     pm_state,
  output logic           regs_rst,
  output logic           spi_rd_en,
  output logic           spi_wr_en,
  output logic           limp_reg_en,
  output logic [NCH-1:0] sw_en
);
  logic [N_DEC-1:0] dec_raw, dec_q;
  pm_state_e        st;
  logic             act_ready;
  logic             is_active;

  assign dec_raw[DEC_VIN]  = vin_good;
  assign dec_raw[DEC_EN]   = en_good;
  assign dec_raw[DEC_IVCC] = ivcc_good;
  assign dec_raw[DEC_EXT]  = ivcc_ext_good;
  assign dec_raw[DEC_VDD]  = vdd_good;
  assign dec_raw[DEC_LIMP] = limp_req;
  assign dec_raw[DEC_IDLE] = sw_idle;

  generate
    for (genvar g = 0; g < N_DEC; g++) begin : g_filt
      pmc_deglitch #(.FILT_CYC(FILT_CYC)) u_flt (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (dec_raw[g]),
        .qual (dec_q[g])
      );
    end
  endgenerate

  pmc_fsm #(.ACT_CYC(ACT_CYC)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (dec_q),
    .state    (st),
    .reg_rst  (regs_rst),
    .act_ready(act_ready)
  );

  assign is_active = (st == PM_ACTIVE);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      pmc_chan_gate u_gate (
        .active   (is_active),
        .act_ready(act_ready),
        .pwm_pin  (pwm_pin[c]),
        .pwm_bit  (pwm_bit[c]),
        .bst_uv   (bst_uv[c]),
        .sw_en    (sw_en[c])
      );
      AST_BST_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        bst_uv[c] |-> !sw_en[c]); // R8
    end
  endgenerate

  assign pm_state    = st;
  assign spi_rd_en   = dec_q[DEC_VDD] & (st != PM_SLEEP);
  assign spi_wr_en   = dec_q[DEC_VDD] & (st == PM_IDLE || st == PM_ACTIVE);
  assign limp_reg_en = (st == PM_LIMP) & dec_q[DEC_VIN] & dec_q[DEC_EXT];

  AST_LIMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd2) |-> !spi_wr_en); // R7
  AST_SW_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_en) |-> (pm_state == 2'd3)); // R8
  AST_SLEEP_NO_SPI: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0) |-> (!spi_rd_en && !spi_wr_en)); // R12

endmodule

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;
  localparam int unsigned NCH = 2;
  localparam int unsigned ACT = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic vin_good, en_good, ivcc_good, ivcc_ext_good, vdd_good, limp_req, sw_idle;
  logic [NCH-1:0] pwm_pin, pwm_bit, bst_uv;
  logic [1:0]     pm_state;
  logic           regs_rst, spi_rd_en, spi_wr_en, limp_reg_en;
  logic [NCH-1:0] sw_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    string          req;
    logic [1:0]     st;
    logic           rr, rd, wr, lr;
    logic [NCH-1:0] sw;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.NCH(NCH), .FILT_CYC(3), .ACT_CYC(ACT)) uut (
    .clk(clk), .rst_n(rst_n), .vin_good(vin_good), .en_good(en_good),
    .ivcc_good(ivcc_good), .ivcc_ext_good(ivcc_ext_good), .vdd_good(vdd_good),
    .limp_req(limp_req), .sw_idle(sw_idle), .pwm_pin(pwm_pin), .pwm_bit(pwm_bit),
    .bst_uv(bst_uv), .pm_state(pm_state), .regs_rst(regs_rst), .spi_rd_en(spi_rd_en),
    .spi_wr_en(spi_wr_en), .limp_reg_en(limp_reg_en), .sw_en(sw_en)
  );

  // monitor: pops expectations and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (pm_state !== e.st || regs_rst !== e.rr || spi_rd_en !== e.rd ||
            spi_wr_en !== e.wr || limp_reg_en !== e.lr || sw_en !== e.sw) begin
          n_fail++;
          $display("FAIL %s: got st=%0d rst=%b rd=%b wr=%b limp=%b sw=%b exp st=%0d rst=%b rd=%b wr=%b limp=%b sw=%b",
                   e.req, pm_state, regs_rst, spi_rd_en, spi_wr_en, limp_reg_en, sw_en,
                   e.st, e.rr, e.rd, e.wr, e.lr, e.sw);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_now(input string r, input logic [1:0] st, input logic rr,
                            input logic rd, input logic wr, input logic lr,
                            input logic [NCH-1:0] sw);
    exp_t e;
    e.req = r; e.st = st; e.rr = rr; e.rd = rd; e.wr = wr; e.lr = lr; e.sw = sw;
    sb.push_back(e);
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    vin_good = 0; en_good = 0; ivcc_good = 0; ivcc_ext_good = 0; vdd_good = 0;
    limp_req = 0; sw_idle = 0;
    pwm_pin = '0; pwm_bit = '0; bst_uv = '0;

    tick(3);
    expect_now("R4 reset", 2'd0, 1, 0, 0, 0, 2'b00);
    rst_n = 1'b1;
    tick(1);
    expect_now("R1 sleep after reset", 2'd0, 0, 0, 0, 0, 2'b00);

    // wake: supplies and enable good
    vin_good = 1; en_good = 1; ivcc_good = 1; ivcc_ext_good = 1; vdd_good = 1;
    pwm_pin = 2'b01;
    tick(3);
    expect_now("R2 not yet moved", 2'd0, 0, 0, 0, 0, 2'b00);
    tick(1);
    expect_now("R9 active entry no switching", 2'd3, 0, 1, 1, 0, 2'b00);
    tick(ACT - 1);
    expect_now("R9 last waiting cycle", 2'd3, 0, 1, 1, 0, 2'b00);
    tick(1);
    expect_now("R9 switching after delay", 2'd3, 0, 1, 1, 0, 2'b01);

    // channel gating
    pwm_bit = 2'b10; bst_uv = 2'b01;
    tick(1);
    expect_now("R8 bit request, bootstrap low blocks", 2'd3, 0, 1, 1, 0, 2'b10);
    pwm_pin = '0; pwm_bit = '0; bst_uv = '0;
    tick(1);
    expect_now("R8 no request", 2'd3, 0, 1, 1, 0, 2'b00);

    // two-cycle glitch on input supply
    vin_good = 0;
    tick(2);
    vin_good = 1;
    tick(4);
    expect_now("R2 glitch ignored", 2'd3, 0, 1, 1, 0, 2'b00);

    // idle
    pwm_pin = 2'b11; sw_idle = 1;
    tick(4);
    expect_now("R3 idle with logic supply", 2'd1, 0, 1, 1, 0, 2'b00);
    vdd_good = 0;
    tick(4);
    expect_now("R3 idle without logic supply", 2'd1, 0, 0, 0, 0, 2'b00);
    vdd_good = 1; sw_idle = 0;
    tick(4);
    expect_now("R9 idle to active no delay", 2'd3, 0, 1, 1, 0, 2'b11);

    // limp-home beats idle
    limp_req = 1; sw_idle = 1;
    tick(4);
    expect_now("R5 R10 limp entry", 2'd2, 1, 1, 0, 1, 2'b00);
    tick(1);
    expect_now("R11 limp strobe one cycle", 2'd2, 0, 1, 0, 1, 2'b00);
    ivcc_ext_good = 0;
    tick(4);
    expect_now("R6 ext regulator lost", 2'd2, 0, 1, 0, 0, 2'b00);
    vdd_good = 0;
    tick(4);
    expect_now("R7 limp without logic supply", 2'd2, 0, 0, 0, 0, 2'b00);

    // input supply loss beats limp
    vin_good = 0;
    tick(4);
    expect_now("R10 supply lost to sleep", 2'd0, 1, 0, 0, 0, 2'b00);
    tick(1);
    expect_now("R11 sleep strobe one cycle", 2'd0, 0, 0, 0, 0, 2'b00);
    vdd_good = 1; ivcc_ext_good = 1;
    tick(4);
    expect_now("R12 sleep blocks serial port", 2'd0, 0, 0, 0, 0, 2'b00);

    // enable low keeps sleep
    vin_good = 1; limp_req = 0; sw_idle = 0; en_good = 0;
    tick(4);
    expect_now("R10 enable low stays sleep", 2'd0, 0, 0, 0, 0, 2'b00);
    en_good = 1;
    tick(4);
    expect_now("R9 R10 re-wake waits again", 2'd3, 0, 1, 1, 0, 2'b00);

    tick(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule